// File: doc/BRIEF.md
# Two-Level Address Translation Unit with Translation Cache

This block turns 32-bit virtual addresses into physical addresses for 4 KB pages. A small fully associative translation cache sits in front of a two-level page table held in memory. A request carries a virtual address and two access attributes: write or read, and user or supervisor. The block compares the page number against every cache slot in the same cycle. On a hit it answers in the next cycle without touching memory.

On a miss the block walks the table in memory. It first reads the directory entry through a single-outstanding read port with a valid/ready handshake, and then reads the second-level entry. It checks the present, writable and user flags. A good translation is written into the cache, into the slot chosen by a rotating pointer, and the physical address is returned. Any failed check returns a fault flag and leaves the cache as it was. The request side stays closed from the start of a walk until the cycle its response appears. A one-cycle flush input drops every cached translation.

Top module: `xlate_walker`

## Requirements
- R1: The virtual address splits into directory index va[31:22], table index va[21:12] and page offset va[11:0]. For va 0x00403004 the first memory read goes to the root base plus 1*4, and the second goes to the table base plus 3*4.
- R2: An entry address is formed by clearing the low 12 bits of the root base or of the directory entry, then adding index*4.
- R3: A successful translation returns paddr = {entry[31:12], va[11:0]} with rsp_fault=0.
- R4: A directory entry with the present bit (bit 0) clear ends the walk after exactly one read, with rsp_fault=1 and rsp_paddr=0.
- R5: A cache hit gives rsp_valid in the cycle after acceptance and makes zero memory reads.
- R6: A second-level entry with the present bit clear gives a fault after two reads and is not cached, so repeating the same request again costs two reads.
- R7: A write needs the writable bit (bit 1) set in both entries. A user access needs the user bit (bit 2) set in both entries. If either check fails the result is a fault and nothing is cached. Hits are checked against the same combined flags, which are kept in the cache.
- R8: The cache holds 8 translations. Fills go to slot 0, 1, ... 7 and then wrap. The rotating pointer is not reset by a flush.
- R9: flush=1 invalidates every slot at that clock edge, and req_ready is low in that cycle.
- R10: After a miss is accepted, req_ready stays low until the cycle its response is driven.
- R11: While mem_rd_valid is high and mem_rd_ready is low, mem_rd_valid stays high and mem_rd_addr is held.
- R12: After reset, req_ready=1, rsp_valid=0 and mem_rd_valid=0, and every cache slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| dir_base | input | 32 | Physical base of the directory (low 12 bits ignored) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Translation failed |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Entry address |
| mem_rd_data_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Entry contents |

## Verification
The hardest state to reach from the ports is the eviction of a particular cached translation. That needs a known pointer position and eight successful fills in between, all confirmed by counting memory reads. The bench keeps its own slot list and rotating pointer, which survive a flush just as the design's do. It fills nine distinct pages after a flush and then revisits the evicted page and a surviving one. The memory model drops mem_rd_ready in a repeating pattern, so the read-hold rule and the busy window are exercised during every walk.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int VA_W     = 32;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 10;
  localparam int PN_W     = VA_W - OFF_W;
  localparam int FLAG_P   = 0;
  localparam int FLAG_W   = 1;
  localparam int FLAG_U   = 2;

  typedef struct packed {
    logic [PN_W-1:0] vpn;
    logic [PN_W-1:0] ppn;
    logic            wr;
    logic            usr;
  } tlb_ent_t;

  function automatic logic [IDX_W-1:0] dir_index(logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] tbl_index(logic [VA_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  function automatic logic [VA_W-1:0] entry_addr(logic [VA_W-1:0] base,
                                                 logic [IDX_W-1:0] idx);
    return {base[VA_W-1:OFF_W], {OFF_W{1'b0}}} +
           {{(VA_W-IDX_W-2){1'b0}}, idx, 2'b00};
  endfunction

  function automatic logic access_ok(logic wr_ok, logic usr_ok,
                                     logic is_wr, logic is_usr);
    return !(is_wr && !wr_ok) && !(is_usr && !usr_ok);
  endfunction
endpackage

// File: rtl/xw_tlb.sv
module xw_tlb
  import xw_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PN_W-1:0] lk_vpn,
  output logic            lk_hit,
  output tlb_ent_t        lk_ent,
  input  logic            fill_en,
  input  tlb_ent_t        fill_ent
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlb_ent_t           ents [ENTRIES];
  logic [ENTRIES-1:0] valid;
  logic [ENTRIES-1:0] hit_vec;
  logic [PTR_W-1:0]   ptr;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (ents[i].vpn == lk_vpn);
  end

  assign lk_hit = |hit_vec;

  always_comb begin
    lk_ent = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) lk_ent = ents[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      ptr   <= '0;
    end else if (flush) begin
      valid <= '0;
    end else if (fill_en) begin
      ents[ptr]  <= fill_ent;
      valid[ptr] <= 1'b1;
      ptr        <= (ptr == PTR_W'(ENTRIES-1)) ? '0 : ptr + 1'b1;
    end
  end

  // R8: at most one slot may match a page number
  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9: a flush leaves no slot able to hit
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);
endmodule

// File: rtl/xw_walker.sv
module xw_walker
  import xw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [VA_W-1:0] dir_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic            req_user,
  input  logic            tlb_hit,
  input  tlb_ent_t        tlb_ent,
  output logic            fill_en,
  output tlb_ent_t        fill_ent,
  output logic            rsp_valid,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_fault,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [VA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_data_valid,
  input  logic [VA_W-1:0] mem_rd_data
);
  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DWAIT, S_TREQ, S_TWAIT} st_t;

  st_t             st;
  logic [VA_W-1:0] va_q, root_q;
  logic            wr_q, usr_q;
  logic [PN_W-1:0] pde_frame_q;
  logic            pde_w_q, pde_u_q;

  // named internal events
  logic accept, hit_ev, miss_ev, dir_ev, tbl_ev, pde_present;
  logic eff_w, eff_u, tbl_ok, hit_ok;

  assign req_ready   = (st == S_IDLE) && !flush;
  assign accept      = req_valid && req_ready;
  assign hit_ev      = accept && tlb_hit;
  assign miss_ev     = accept && !tlb_hit;
  assign dir_ev      = (st == S_DWAIT) && mem_rd_data_valid;
  assign tbl_ev      = (st == S_TWAIT) && mem_rd_data_valid;
  assign pde_present = mem_rd_data[FLAG_P];
  assign eff_w       = pde_w_q && mem_rd_data[FLAG_W];
  assign eff_u       = pde_u_q && mem_rd_data[FLAG_U];
  assign tbl_ok      = tbl_ev && mem_rd_data[FLAG_P] &&
                       access_ok(eff_w, eff_u, wr_q, usr_q);
  assign hit_ok      = access_ok(tlb_ent.wr, tlb_ent.usr, req_write, req_user);

  assign mem_rd_valid = (st == S_DREQ) || (st == S_TREQ);
  assign mem_rd_addr  = (st == S_TREQ) ?
                        entry_addr({pde_frame_q, {OFF_W{1'b0}}}, tbl_index(va_q)) :
                        entry_addr(root_q, dir_index(va_q));

  assign fill_en  = tbl_ok;
  assign fill_ent = '{vpn: va_q[VA_W-1:OFF_W], ppn: mem_rd_data[VA_W-1:OFF_W],
                      wr: eff_w, usr: eff_u};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_paddr   <= '0;
      va_q        <= '0;
      root_q      <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      pde_frame_q <= '0;
      pde_w_q     <= 1'b0;
      pde_u_q     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (hit_ev) begin
            rsp_valid <= 1'b1;
            rsp_fault <= !hit_ok;
            rsp_paddr <= hit_ok ? {tlb_ent.ppn, req_vaddr[OFF_W-1:0]} : '0;
          end else if (miss_ev) begin
            va_q   <= req_vaddr;
            root_q <= dir_base;
            wr_q   <= req_write;
            usr_q  <= req_user;
            st     <= S_DREQ;
          end
        end
        S_DREQ: if (mem_rd_ready) st <= S_DWAIT;
        S_DWAIT: begin
          if (dir_ev) begin
            if (pde_present) begin
              pde_frame_q <= mem_rd_data[VA_W-1:OFF_W];
              pde_w_q     <= mem_rd_data[FLAG_W];
              pde_u_q     <= mem_rd_data[FLAG_U];
              st          <= S_TREQ;
            end else begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
              st        <= S_IDLE;
            end
          end
        end
        S_TREQ: if (mem_rd_ready) st <= S_TWAIT;
        S_TWAIT: begin
          if (tbl_ev) begin
            rsp_valid <= 1'b1;
            rsp_fault <= !tbl_ok;
            rsp_paddr <= tbl_ok ? {mem_rd_data[VA_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11: a stalled read holds its request and address
  a_r11_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R4: a missing directory entry ends the walk with a fault
  a_r4_dir_fault: assert property (@(posedge clk) disable iff (!rst_n)
    dir_ev && !pde_present |=> rsp_valid && rsp_fault && !mem_rd_valid);

  // R5: a hit answers next cycle without a memory read
  a_r5_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> rsp_valid && !mem_rd_valid);

  // R10: a miss starts a read and closes the request side
  a_r10_miss_busy: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ev |=> mem_rd_valid && !req_ready && !rsp_valid);

  // R6: only a good translation is cached
  a_r6_fill_good: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> rsp_valid && !rsp_fault);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xw_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [VA_W-1:0] dir_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic            req_user,
  output logic            rsp_valid,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_fault,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [VA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_data_valid,
  input  logic [VA_W-1:0] mem_rd_data
);
  logic     tlb_hit, fill_en;
  tlb_ent_t tlb_ent, fill_ent;

  xw_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
    .lk_hit   (tlb_hit),
    .lk_ent   (tlb_ent),
    .fill_en  (fill_en),
    .fill_ent (fill_ent)
  );

  xw_walker u_walk (
    .clk               (clk),
    .rst_n             (rst_n),
    .flush             (flush),
    .dir_base          (dir_base),
    .req_valid         (req_valid),
    .req_ready         (req_ready),
    .req_vaddr         (req_vaddr),
    .req_write         (req_write),
    .req_user          (req_user),
    .tlb_hit           (tlb_hit),
    .tlb_ent           (tlb_ent),
    .fill_en           (fill_en),
    .fill_ent          (fill_ent),
    .rsp_valid         (rsp_valid),
    .rsp_paddr         (rsp_paddr),
    .rsp_fault         (rsp_fault),
    .mem_rd_valid      (mem_rd_valid),
    .mem_rd_ready      (mem_rd_ready),
    .mem_rd_addr       (mem_rd_addr),
    .mem_rd_data_valid (mem_rd_data_valid),
    .mem_rd_data       (mem_rd_data)
  );
endmodule

// File: tb/tb_xlate_walker.sv
module tb_xlate_walker;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, flush = 1'b0;
  logic [31:0] dir_base = 32'h0010_0000;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault, mem_rd_valid;
  logic [31:0] rsp_paddr, mem_rd_addr;
  logic        mem_rd_ready = 1'b0, mem_rd_data_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  xlate_walker dut (.*);

  int checks = 0, fails = 0;
  int rd_cnt = 0, rsp_cnt = 0, rdy_phase = 0;
  logic [31:0] rd_addr [2];
  logic [31:0] pmem [logic [31:0]];

  logic [31:0] q_pa[$];
  logic        q_flt[$];
  int          q_rd[$];
  string       q_tag[$];

  // bench-side cache model
  logic [19:0] m_vpn [8];
  bit          m_v   [8];
  int          m_ptr = 0;

  bit          hold_pend = 0;
  logic [31:0] hold_addr;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mrd(logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  // memory model: ready drops every third cycle, data one cycle after accept
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rd_ready      <= 1'b0;
      mem_rd_data_valid <= 1'b0;
    end else begin
      rdy_phase         <= rdy_phase + 1;
      mem_rd_ready      <= (rdy_phase % 3) != 0;
      mem_rd_data_valid <= mem_rd_valid && mem_rd_ready;
      mem_rd_data       <= mrd(mem_rd_addr);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(mem_rd_valid && mem_rd_addr == hold_addr, "R11", "stalled read held",
            mem_rd_addr, hold_addr);
      hold_pend = mem_rd_valid && !mem_rd_ready;
      hold_addr = mem_rd_addr;
      if (mem_rd_valid && mem_rd_ready) begin
        if (rd_cnt < 2) rd_addr[rd_cnt] = mem_rd_addr;
        rd_cnt++;
      end
      if (rsp_valid) begin
        if (q_pa.size() == 0) begin
          chk(0, "R5", "unexpected response", rsp_paddr, 0);
        end else begin
          logic [31:0] epa; logic ef; int er; string t;
          epa = q_pa.pop_front(); ef = q_flt.pop_front();
          er = q_rd.pop_front(); t = q_tag.pop_front();
          chk(rsp_paddr == epa, t, "paddr", rsp_paddr, epa);
          chk(rsp_fault == ef, t, "fault", {31'b0, rsp_fault}, {31'b0, ef});
          chk(rd_cnt == er, t, "memory reads", rd_cnt, er);
        end
        rsp_cnt++;
      end
    end
  end

  task automatic xlate(logic [31:0] va, bit wr, bit us, string tag);
    logic [31:0] pde, pte, pa; bit ok, hit; int nrd, prev;
    hit = 0;
    for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == va[31:12]) hit = 1;
    pde = mrd({dir_base[31:12], 12'h0} + 32'(va[31:22]) * 4);
    if (!pde[0]) begin
      ok = 0; nrd = 1; pte = 0;
    end else begin
      pte = mrd({pde[31:12], 12'h0} + 32'(va[21:12]) * 4);
      nrd = 2;
      ok = pte[0] && !(wr && !(pde[1] && pte[1])) && !(us && !(pde[2] && pte[2]));
    end
    pa = ok ? {pte[31:12], va[11:0]} : 32'h0;
    if (hit) nrd = 0;
    q_pa.push_back(pa); q_flt.push_back(!ok); q_rd.push_back(nrd); q_tag.push_back(tag);
    prev = rsp_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_cnt = 0;
    req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk); #1;
    if (nrd > 0) chk(req_ready == 1'b0, "R10", "busy during walk", {31'b0, req_ready}, 0);
    else chk(rsp_cnt > prev, "R5", "hit response next cycle", rsp_cnt, prev + 1);
    wait (rsp_cnt > prev);
    if (!hit && ok) begin
      m_vpn[m_ptr] = va[31:12]; m_v[m_ptr] = 1; m_ptr = (m_ptr + 1) % 8;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    pmem[32'h0010_0004] = 32'h0020_0007;
    pmem[32'h0010_000C] = 32'h0030_0003;
    pmem[32'h0030_0000] = 32'h0060_0007;
    pmem[32'h0020_000C] = 32'h0050_0007;
    pmem[32'h0020_0014] = 32'h0051_0005;
    pmem[32'h0020_0018] = 32'h0052_0003;
    for (int i = 16; i < 25; i++)
      pmem[32'h0020_0000 + 32'(i) * 4] = 32'h0070_0007 + (32'(i) << 12);
    for (int i = 0; i < 8; i++) m_v[i] = 0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "ready after reset", {31'b0, req_ready}, 1);
    chk(rsp_valid == 1'b0, "R12", "no response after reset", {31'b0, rsp_valid}, 0);
    chk(mem_rd_valid == 1'b0, "R12", "no read after reset", {31'b0, mem_rd_valid}, 0);

    xlate(32'h0040_3004, 0, 1, "R3");
    chk(rd_addr[0] == 32'h0010_0004, "R1", "directory read address", rd_addr[0], 32'h0010_0004);
    chk(rd_addr[1] == 32'h0020_000C, "R2", "table read address", rd_addr[1], 32'h0020_000C);
    xlate(32'h0040_3FFC, 0, 1, "R5");
    xlate(32'h0080_0123, 0, 0, "R4");
    xlate(32'h0040_4000, 0, 0, "R6");
    xlate(32'h0040_4000, 0, 0, "R6");
    xlate(32'h0040_5010, 1, 1, "R7");
    xlate(32'h0040_5010, 0, 1, "R7");
    xlate(32'h0040_5010, 1, 1, "R7");
    xlate(32'h0040_6020, 0, 1, "R7");
    xlate(32'h0040_6020, 1, 0, "R7");
    xlate(32'h00C0_0008, 0, 1, "R7");
    xlate(32'h00C0_0008, 1, 0, "R7");

    @(negedge clk);
    flush = 1'b1; #1;
    chk(req_ready == 1'b0, "R9", "no accept in flush cycle", {31'b0, req_ready}, 0);
    @(posedge clk); #1 flush = 1'b0;
    for (int i = 0; i < 8; i++) m_v[i] = 0;
    xlate(32'h0040_3004, 0, 0, "R9");

    for (int i = 16; i < 24; i++) xlate(32'h0040_0000 + (32'(i) << 12), 0, 0, "R8");
    for (int i = 16; i < 24; i++) xlate(32'h0040_0000 + (32'(i) << 12), 0, 0, "R8");
    xlate(32'h0041_8000, 0, 0, "R8");
    xlate(32'h0041_0000, 0, 0, "R8");
    xlate(32'h0041_3000, 0, 0, "R8");
    xlate(32'h0040_3004, 0, 0, "R8");

    repeat (4) @(negedge clk);
    chk(q_pa.size() == 0, "R5", "all responses seen", q_pa.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule